// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. A host request carries a direction flag, an address, write data and a two-bit lane mask. It becomes one strobe sequence on the RAM pins: chip enable, write enable, output enable and the two active-low lane enables. The sequence is sized in clock cycles so that the RAM's minimum pulse widths, setup times and cycle times are met at the chosen clock period.

Every nanosecond limit becomes a cycle count: the limit divided by the clock-period parameter, rounded up, with a floor of one. A write holds write enable low for the longer of the pulse-width and data-setup counts. It then raises write enable alone, keeping select, lanes and data in place, and stretches this tail until the whole access covers the write cycle time. A read holds select and output enable low for the longest of the read-cycle, address-to-data, output-enable-to-data and lane-to-data counts. It captures the bus on the last of those cycles. The tri-state data bus is split into separate out, in and drive-enable signals.

The host holds `req` and its fields until `ready` pulses. `ready` goes high for a single cycle once the access has ended. One cycle with every strobe inactive always follows, so the bus turns around before the next access.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and after it is released with no request, chip enable, write enable and output enable are high, both lane enables are high, the data driver is off and `ready` is low.
- R2: A write holds write enable low for exactly WE_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles (minimum one each). Chip enable is low and the data driver is on with the request's write data throughout.
- R3: During an access, lane enable bit 0 (data bits 7:0) is low exactly when mask bit 0 is set, and lane enable bit 1 (data bits 15:8) is low exactly when mask bit 1 is set. This holds for reads and for writes, and a write leaves the byte of a cleared lane unchanged in memory.
- R4: Write enable rises while chip enable is still low, the lane enables are unchanged and the same write data is still driven.
- R5: A write keeps chip enable low for WE_CYC + max(1, ceil(T_WC_NS/CLK_NS) − WE_CYC) cycles.
- R6: A read keeps chip enable and output enable low with write enable high for RD_CYC cycles. RD_CYC is the largest of the rounded-up read-cycle, address-to-data, output-enable-to-data and lane-to-data limits. The data driver is never on while output enable is low.
- R7: Read data is taken from the bus in the last read cycle. The byte of a lane whose mask bit is clear reads as zero.
- R8: `ready` is high for exactly one cycle, the cycle after the access's last strobe cycle, and `rdata` holds the read result then. A request held from idle sees `ready` after access-length + 1 cycles.
- R9: The RAM address and write data stay at the values taken when the request was accepted while chip enable is low, even if the host inputs change.
- R10: A request is accepted only from idle, so each request yields exactly one access. At least two cycles with chip enable high separate consecutive accesses, including a write that follows a read with no pause on the host side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until `ready` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 8*LANES | Write data |
| mask | input | LANES | Lane select, bit i = byte i |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8*LANES | Read result, unselected bytes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | LANES | RAM lane enables, active low, bit 0 = bits 7:0 |
| mem_dout | output | 8*LANES | Data toward the RAM |
| mem_din | input | 8*LANES | Data from the RAM |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |

## Verification
Every result has a fixed due cycle counted from the host's edge. A request set before edge 0 moves the controller out of idle at that edge. `ready` is due at the (len+1)th falling edge after the request, and one cycle later when the request follows `ready` with no pause. Strobe run lengths are measured between falling-edge samples and compared with counts the bench derives from the nanosecond parameters. The bench's RAM model returns garbage until the required number of output-enable cycles has passed, so a capture even one cycle early shows up as a data miscompare.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 8,
  parameter int T_WP_NS = 35,
  parameter int T_DS_NS = 25,
  parameter int T_WC_NS = 45,
  parameter int T_RC_NS = 45,
  parameter int T_AA_NS = 45,
  parameter int T_OE_NS = 25,
  parameter int T_BE_NS = 45
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   wdata,
  input  logic [LANES-1:0]     mask,
  output logic                 ready,
  output logic [8*LANES-1:0]   rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ce_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [LANES-1:0]     mem_be_n,
  output logic [8*LANES-1:0]   mem_dout,
  input  logic [8*LANES-1:0]   mem_din,
  output logic                 mem_dout_en
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DW       = 8 * LANES;
  localparam int WE_CYC   = imax(cyc(T_WP_NS), cyc(T_DS_NS));
  localparam int HOLD_CYC = imax(1, cyc(T_WC_NS) - WE_CYC);
  localparam int RD_CYC   = imax(imax(cyc(T_RC_NS), cyc(T_AA_NS)),
                                 imax(cyc(T_OE_NS), cyc(T_BE_NS)));
  localparam int MAX_CYC  = imax(imax(WE_CYC, HOLD_CYC), RD_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WRP, S_WRH, S_RD, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    cap;
  logic             active;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cap[8*i +: 8] = mask_q[i] ? mem_din[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mem_addr <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      rdata    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          data_q   <= wdata;
          mask_q   <= mask;
          if (wr) begin
            st  <= S_WRP;
            cnt <= CNT_W'(WE_CYC - 1);
          end else begin
            st  <= S_RD;
            cnt <= CNT_W'(RD_CYC - 1);
          end
        end
        S_WRP: if (cnt == '0) begin
          st  <= S_WRH;
          cnt <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WRH: if (cnt == '0) st <= S_DONE;
               else cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          st    <= S_DONE;
          rdata <= cap;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active      = (st == S_WRP) || (st == S_WRH) || (st == S_RD);
  assign mem_ce_n    = !active;
  assign mem_we_n    = (st != S_WRP);
  assign mem_oe_n    = (st != S_RD);
  assign mem_be_n    = active ? ~mask_q : '1;
  assign mem_dout    = data_q;
  assign mem_dout_en = (st == S_WRP) || (st == S_WRH);
  assign ready       = (st == S_DONE);

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dout_en && mem_we_n);

  // R2
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n && mem_dout_en && mem_oe_n);

  // R4
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_ce_n && mem_dout_en && $stable(mem_dout) && $stable(mem_be_n));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr) && $stable(mem_dout));

  // R10
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> $past(!ready));

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int ADDR_W = 18, CLK_NS = 8;
  localparam int T_WP = 35, T_DS = 25, T_WC = 45, T_RC = 45, T_AA = 45, T_OE = 25, T_BE = 45;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WE_CYC = imax(cyc(T_WP), cyc(T_DS));
  localparam int WC_TOT = WE_CYC + imax(1, cyc(T_WC) - WE_CYC);
  localparam int RD_CYC = imax(imax(cyc(T_RC), cyc(T_AA)), imax(cyc(T_OE), cyc(T_BE)));

  logic clk = 0, rst = 1;
  logic req = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] mask = '0;
  logic ready;
  logic [15:0] rdata, mem_dout, mem_din;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [1:0] mem_be_n;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(ADDR_W), .LANES(2), .CLK_NS(CLK_NS), .T_WP_NS(T_WP),
    .T_DS_NS(T_DS), .T_WC_NS(T_WC), .T_RC_NS(T_RC), .T_AA_NS(T_AA),
    .T_OE_NS(T_OE), .T_BE_NS(T_BE)) dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .mask(mask), .ready(ready), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_dout_en(mem_dout_en));

  int vectors = 0, errs = 0;
  logic [15:0] ram [16];
  logic [15:0] shadow [16];
  int rd_age = 0;

  bit cur_wr = 0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [15:0] cur_data = '0;
  logic [1:0] cur_mask = '0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // RAM model: data valid only after RD_CYC output-enable cycles, garbage otherwise
  always_comb begin
    mem_din = 16'hBAD5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RD_CYC) begin
      mem_din[7:0]  = mem_be_n[0] ? 8'hE7 : ram[mem_addr[3:0]][7:0];
      mem_din[15:8] = mem_be_n[1] ? 8'h7E : ram[mem_addr[3:0]][15:8];
    end
  end

  bit prev_we = 1, prev_ce = 1, seen = 0;
  int we_run = 0, ce_run = 0, gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n && !mem_oe_n) rd_age <= rd_age + 1; else rd_age <= 0;
      if (mem_dout_en && !mem_oe_n) chk(0, "R6 bus fight", 1, 0);
      if (!mem_ce_n) begin
        if (mem_be_n != ~cur_mask) chk(0, "R3 lane enables", mem_be_n, ~cur_mask);
        if (mem_addr != cur_addr) chk(0, "R9 address", mem_addr, cur_addr);
        ce_run++;
      end
      if (!mem_we_n) begin
        we_run++;
        if (!(mem_dout_en && !mem_ce_n && mem_dout == cur_data))
          chk(0, "R2 write data", mem_dout, cur_data);
      end
      if (mem_we_n && !prev_we) begin
        chk(we_run == WE_CYC, "R2 we pulse", we_run, WE_CYC);
        chk(!mem_ce_n && mem_dout_en && mem_dout == cur_data && mem_be_n == ~cur_mask,
            "R4 write end", {mem_ce_n, mem_dout_en, mem_dout}, {1'b0, 1'b1, cur_data});
        if (!mem_be_n[0]) ram[mem_addr[3:0]][7:0]  = mem_dout[7:0];
        if (!mem_be_n[1]) ram[mem_addr[3:0]][15:8] = mem_dout[15:8];
        we_run = 0;
      end
      if (mem_ce_n && !prev_ce) begin
        chk(ce_run == (cur_wr ? WC_TOT : RD_CYC), cur_wr ? "R5 write cycle" : "R6 read cycle",
            ce_run, cur_wr ? WC_TOT : RD_CYC);
        ce_run = 0;
      end
      if (mem_ce_n) gap++;
      if (!mem_ce_n && prev_ce) begin
        if (seen) chk(gap >= 2, "R10 gap", gap, 2);
        seen = 1; gap = 0;
      end
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
    end
  end

  task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit chain);
    int lat, exp_lat;
    if (!chain) begin
      @(negedge clk);
      chk(ready == 0, "R8 ready one cycle", ready, 0);
    end
    req = 1; wr = w; addr = a; wdata = d; mask = m;
    cur_wr = w; cur_addr = a; cur_data = d; cur_mask = m;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 3) begin addr = ~a; wdata = ~d; mask = ~m; wr = ~w; end
    end while (!ready && lat < 200);
    exp_lat = (w ? WC_TOT : RD_CYC) + (chain ? 2 : 1);
    chk(lat == exp_lat, "R8 latency", lat, exp_lat);
    if (w) begin
      if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
    end else begin
      chk(rdata == (shadow[a[3:0]] & lmask(m)), "R7 read data", rdata, shadow[a[3:0]] & lmask(m));
    end
    req = 0;
  endtask

  function automatic logic [ADDR_W-1:0] adr(input int i);
    return ADDR_W'((i << 14) | (i * 16) | i) & ADDR_W'(18'h3C00F) | ADDR_W'(i);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin ram[i] = 16'h0; shadow[i] = 16'h0; end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dout_en && !ready,
        "R1 reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dout_en, ready}, 7'b1111100);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dout_en && !ready,
        "R1 idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dout_en, ready}, 7'b1111100);
    for (int i = 0; i < 16; i++)
      access(1, adr(i), 16'(i * 16'h1357 ^ 16'hA5C3), 2'b11, 0);
    for (int i = 0; i < 16; i++) begin
      for (int m = 0; m < 4; m++) begin
        access(1, adr(i), 16'((i + 3) * 16'h2B1D ^ m * 16'h0F0F), 2'(m), 0);
        for (int r = 0; r < 4; r++)
          access(0, adr(i), 16'h0, 2'(r), (r % 2) == 1);
        access(1, adr((i + 5) % 16), 16'(i * 16'h0101 + m), 2'(3 - m), 1);
      end
    end
    // R3: unwritten lanes unchanged, checked through full reads
    for (int i = 0; i < 16; i++) access(0, adr(i), 16'h0, 2'b11, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule